// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Interrupt Sensing

The block is a 32-pin general-purpose I/O port behind a simple word bus. The bus has an address, a write strobe, write data and combinational read data. Software sets a drive value and a direction bit for each pin. It reads back the pad levels after they pass through a resynchronizing flop chain. The pad itself is modelled only as an enable vector and a value vector, which the chip's pad ring uses to drive the tri-state buffers.

Every pin has its own interrupt sensing with four triggers: low level, high level, rising edge and falling edge. A detected event sets a sticky pending bit. Software clears a pending bit by writing a one to it. A per-pin enable mask gates the pending bits onto two interrupt lines. One line collects the lower half of the port and the other collects the upper half. This lets the two halves be routed to different interrupt controller inputs.

Top module: `gpx_port`

## Requirements
- R1: While reset is held, `pad_oe`, `pad_out`, `irq_lo` and `irq_hi` are zero and every register reads zero.
- R2: Byte offset 0x00 holds the drive values and offset 0x04 holds the direction. Both read back the last value written. `pad_out` follows the drive register, and a direction bit of 1 sets the matching `pad_oe` bit, making that pin an output.
- R3: Offset 0x08 returns the pad level of every pin, whatever its direction, two clock edges after the pad changes. Writes to 0x08 change no register.
- R4: Each pin has a 2-bit trigger code: 0 low level, 1 high level, 2 rising edge, 3 falling edge. Pins 0–15 take their code from offset 0x0C and pins 16–31 from offset 0x10. Pin n uses bits [2*(n mod 16)+1 : 2*(n mod 16)].
- R5: With a level trigger, the pending bit is set on every cycle the synchronized level matches the trigger, so a clear is undone while the condition lasts.
- R6: With an edge trigger, the pending bit is set once, on the cycle the synchronized level differs from its previous value in the selected direction. A steady level sets nothing.
- R7: Pending bits sit at offset 0x18 and stay set until cleared. Writing 1 to a bit clears it, and writing 0 leaves it as it is.
- R8: When a hardware event and a clear write hit the same pending bit in the same cycle, the bit ends up set.
- R9: Offset 0x14 is the enable mask, reset to zero. `irq_lo` is the OR of the pending-and-enabled bits of pins 0–15, and `irq_hi` is the same OR for pins 16–31.
- R10: Reads of any offset outside the seven listed ones return zero.
- R11: Under random interleaved pad activity, register writes and reads, every read and every output matches a cycle-accurate model of R2–R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Raw pad levels, asynchronous |
| pad_oe | output | 32 | Per-pin output enable for the pad drivers |
| pad_out | output | 32 | Per-pin drive value for the pad drivers |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |

## Verification
A corrupt synchronizer or previous-level register shows up as a pad-status read that disagrees two edges after a pad change, or as an edge-triggered pending bit that appears or fails to appear three edges after it. A wrong trigger decode or a dropped set-over-clear priority changes the pending word on the very next edge after a clear write. The bench reads that word back at once. A mask or grouping fault shows on `irq_lo` or `irq_hi` in the same cycle the pending or mask state changes. The bench compares both lines on every cycle of the random phase.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   localparam int BUS_W = 32;

   typedef enum logic [1:0] {
      TRIG_LOW  = 2'd0,
      TRIG_HIGH = 2'd1,
      TRIG_RISE = 2'd2,
      TRIG_FALL = 2'd3
   } trig_e;

   // byte offsets of the register window
   localparam int OFS_DRIVE = 'h00;
   localparam int OFS_DIR   = 'h04;
   localparam int OFS_PAD   = 'h08;
   localparam int OFS_TRG_L = 'h0C;
   localparam int OFS_TRG_H = 'h10;
   localparam int OFS_MASK  = 'h14;
   localparam int OFS_PEND  = 'h18;

   function automatic logic trig_hit(trig_e t, logic now, logic old);
      logic r;
      unique case (t)
         TRIG_LOW:  r = ~now;
         TRIG_HIGH: r = now;
         TRIG_RISE: r = now & ~old;
         TRIG_FALL: r = ~now & old;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("gpx_sync: STAGES must be 2..4");
   end
   if (W < 1) begin : g_bad_width
      $error("gpx_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpx_sense.sv
module gpx_sense
   import gpx_pkg::*;
#(
   parameter int NPINS = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NPINS-1:0]   lvl,
   input  logic [2*NPINS-1:0] cfg,
   output logic [NPINS-1:0]   hit
);
   logic [NPINS-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign hit[i] = trig_hit(trig_e'(cfg[2*i +: 2]), lvl[i], prev[i]);

      // edge codes (bit 1 set) only fire when the level moved
      AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg[2*i+1] && hit[i]) |-> (lvl[i] != prev[i])); // R6
   end
endmodule

// File: rtl/gpx_port.sv
module gpx_port
   import gpx_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pad_out,
   output logic              irq_lo,
   output logic              irq_hi
);
   localparam int HALF   = NPINS / 2;
   localparam int CFG_W  = 2 * HALF;
   localparam int GROUPS = 2;

   if (NPINS < 2 || NPINS > BUS_W || (NPINS % 2) != 0) begin : g_bad_npins
      $error("gpx_port: NPINS must be even and 2..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("gpx_port: ADDR_W too narrow for the register window");
   end

   logic [NPINS-1:0] r_drive, r_dir, r_mask, r_pend;
   logic [CFG_W-1:0] r_trg_l, r_trg_h;
   logic [NPINS-1:0] lvl, hit, clr, pend_en;
   logic [GROUPS-1:0] grp_irq;

   logic sel_drive, sel_dir, sel_pad, sel_trg_l, sel_trg_h, sel_mask, sel_pend;
   assign sel_drive = (bus_addr == ADDR_W'(OFS_DRIVE));
   assign sel_dir   = (bus_addr == ADDR_W'(OFS_DIR));
   assign sel_pad   = (bus_addr == ADDR_W'(OFS_PAD));
   assign sel_trg_l = (bus_addr == ADDR_W'(OFS_TRG_L));
   assign sel_trg_h = (bus_addr == ADDR_W'(OFS_TRG_H));
   assign sel_mask  = (bus_addr == ADDR_W'(OFS_MASK));
   assign sel_pend  = (bus_addr == ADDR_W'(OFS_PEND));

   gpx_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (lvl)
   );

   gpx_sense #(.NPINS(NPINS)) u_sense (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (lvl),
      .cfg  ({r_trg_h, r_trg_l}),
      .hit  (hit)
   );

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_drive <= '0;
         r_dir   <= '0;
         r_trg_l <= '0;
         r_trg_h <= '0;
         r_mask  <= '0;
      end else if (bus_we) begin
         if (sel_drive) r_drive <= bus_wdata[NPINS-1:0];
         if (sel_dir)   r_dir   <= bus_wdata[NPINS-1:0];
         if (sel_trg_l) r_trg_l <= bus_wdata[CFG_W-1:0];
         if (sel_trg_h) r_trg_h <= bus_wdata[CFG_W-1:0];
         if (sel_mask)  r_mask  <= bus_wdata[NPINS-1:0];
      end
   end

   // pending bits: clear by write-one, hardware set takes priority
   assign clr = (bus_we && sel_pend) ? bus_wdata[NPINS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_pend <= '0;
      else        r_pend <= (r_pend & ~clr) | hit;
   end

   assign pend_en = r_pend & r_mask;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign grp_irq[g] = |pend_en[g*HALF +: HALF];
   end
   assign irq_lo = grp_irq[0];
   assign irq_hi = grp_irq[1];

   assign pad_oe  = r_dir;
   assign pad_out = r_drive;

   always_comb begin
      bus_rdata = '0;
      unique case (1'b1)
         sel_drive: bus_rdata[NPINS-1:0] = r_drive;
         sel_dir:   bus_rdata[NPINS-1:0] = r_dir;
         sel_pad:   bus_rdata[NPINS-1:0] = lvl;
         sel_trg_l: bus_rdata[CFG_W-1:0] = r_trg_l;
         sel_trg_h: bus_rdata[CFG_W-1:0] = r_trg_h;
         sel_mask:  bus_rdata[NPINS-1:0] = r_mask;
         sel_pend:  bus_rdata[NPINS-1:0] = r_pend;
         default:   bus_rdata = '0;
      endcase
   end

   // ---------------- assertions ----------------
   logic mapped;
   assign mapped = sel_drive | sel_dir | sel_pad | sel_trg_l | sel_trg_h | sel_mask | sel_pend;

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && sel_pend) |=> ((r_pend & $past(r_pend)) == $past(r_pend))); // R7
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel_pend) |=> ((r_pend & $past(bus_wdata[NPINS-1:0] & ~hit)) == '0)); // R7
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((r_pend & $past(hit)) == $past(hit))); // R8
   AST_PAD_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel_pad) |=> ($stable(r_drive) && $stable(r_dir) && $stable(r_mask)
                               && $stable(r_trg_l) && $stable(r_trg_h))); // R3
   AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (r_mask == '0) |-> (!irq_lo && !irq_hi)); // R9
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (bus_rdata == '0)); // R10
endmodule

// File: tb/gpx_port_bench.sv
`timescale 1ns/1ps
module gpx_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_oe, pad_out;
   logic        irq_lo, irq_hi;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   gpx_port u_gpx_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   // ---------- reference model built from the requirements ----------
   logic [31:0] m_drive, m_dir, m_s1, m_s2, m_prev, m_tl, m_th, m_mask, m_pend;

   function automatic logic [1:0] code_of(int n, logic [31:0] lo, logic [31:0] hi);
      return (n < 16) ? lo[2*n +: 2] : hi[2*(n-16) +: 2];
   endfunction

   function automatic logic [31:0] events(logic [31:0] now, logic [31:0] old,
                                          logic [31:0] lo, logic [31:0] hi);
      logic [31:0] e;
      for (int n = 0; n < 32; n++) begin
         case (code_of(n, lo, hi))
            2'd0: e[n] = !now[n];
            2'd1: e[n] = now[n];
            2'd2: e[n] = now[n] && !old[n];
            default: e[n] = !now[n] && old[n];
         endcase
      end
      return e;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_drive <= '0; m_dir <= '0; m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
         m_tl <= '0; m_th <= '0; m_mask <= '0; m_pend <= '0;
      end else begin
         m_s1 <= pad_in;
         m_s2 <= m_s1;
         m_prev <= m_s2;
         m_pend <= (m_pend & ~((bus_we && bus_addr == 8'h18) ? bus_wdata : 32'h0))
                   | events(m_s2, m_prev, m_tl, m_th);
         if (bus_we) begin
            case (bus_addr)
               8'h00: m_drive <= bus_wdata;
               8'h04: m_dir   <= bus_wdata;
               8'h0C: m_tl    <= bus_wdata;
               8'h10: m_th    <= bus_wdata;
               8'h14: m_mask  <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] exp_read(logic [7:0] a);
      case (a)
         8'h00: return m_drive;
         8'h04: return m_dir;
         8'h08: return m_s2;
         8'h0C: return m_tl;
         8'h10: return m_th;
         8'h14: return m_mask;
         8'h18: return m_pend;
         default: return 32'h0;
      endcase
   endfunction

   // ---------- helpers ----------
   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         summary();
      end
   end

   // ---------- stimulus ----------
   initial begin
      logic [31:0] d, snap;
      void'($urandom(32'd1234));

      // R1: reset state
      wait_n(3);
      chk("R1 pad_oe", pad_oe, 32'h0);
      chk("R1 pad_out", pad_out, 32'h0);
      chk("R1 irq", {30'h0, irq_hi, irq_lo}, 32'h0);
      for (int a = 0; a <= 'h18; a += 4) rd_chk("R1 regs", 8'(a), 32'h0);

      @(negedge clk); rst_n = 1'b1;

      // R5: all pins default to low-level trigger with pads low
      wait_n(4);
      rd_chk("R5 level sets", 8'h18, 32'hFFFF_FFFF);
      // R8: clear while the level still holds -> stays set
      wr(8'h18, 32'hFFFF_FFFF);
      rd_chk("R8 set wins", 8'h18, 32'hFFFF_FFFF);

      // R4 + R7: switch to high-level, then clear
      wr(8'h0C, 32'h5555_5555);
      wr(8'h10, 32'h5555_5555);
      rd_chk("R4 cfg low readback", 8'h0C, 32'h5555_5555);
      wait_n(2);
      wr(8'h18, 32'hFFFF_FFFF);
      rd_chk("R7 cleared", 8'h18, 32'h0);

      // R6: pin 5 rising edge (bits 11:10 = 2)
      wr(8'h0C, (32'h5555_5555 & ~32'h0000_0C00) | 32'h0000_0800);
      pad_in[5] = 1'b1;
      wait_n(4);
      rd_chk("R6 rise sets pin5", 8'h18, 32'h0000_0020);
      wr(8'h18, 32'h0000_0020);
      wait_n(3);
      rd_chk("R6 steady high no reset", 8'h18, 32'h0);

      // R6: pin 20 falling edge (high reg bits 9:8 = 3)
      wr(8'h10, 32'h5555_5555 | 32'h0000_0300);
      pad_in[20] = 1'b1;
      wait_n(4);
      rd_chk("R6 fall idle", 8'h18, 32'h0);
      pad_in[20] = 1'b0;
      wait_n(4);
      rd_chk("R6 fall sets pin20", 8'h18, 32'h0010_0000);

      // R9: mask routing to the two lines
      pad_in[5] = 1'b0;
      wait_n(3);
      pad_in[5] = 1'b1;
      wait_n(4);
      wr(8'h14, 32'h0000_0020);
      #1 chk("R9 low line", {30'h0, irq_hi, irq_lo}, 32'h1);
      wr(8'h14, 32'h0010_0000);
      #1 chk("R9 high line", {30'h0, irq_hi, irq_lo}, 32'h2);
      wr(8'h18, 32'h0010_0000);
      #1 chk("R9 cleared drop", {30'h0, irq_hi, irq_lo}, 32'h0);

      // R2 + R3: direction, drive, pad status
      wr(8'h04, 32'hFFFF_0000);
      wr(8'h00, 32'hA5A5_5A5A);
      #1 chk("R2 pad_oe", pad_oe, 32'hFFFF_0000);
      chk("R2 pad_out", pad_out, 32'hA5A5_5A5A);
      rd_chk("R2 drive readback", 8'h00, 32'hA5A5_5A5A);
      pad_in = 32'h1357_9BDF;
      wait_n(3);
      rd_chk("R3 pad level", 8'h08, 32'h1357_9BDF);
      wr(8'h08, 32'hFFFF_FFFF);
      rd_chk("R3 pad write ignored", 8'h08, 32'h1357_9BDF);
      rd_chk("R3 drive untouched", 8'h00, 32'hA5A5_5A5A);
      rd_chk("R3 dir untouched", 8'h04, 32'hFFFF_0000);

      // R10: unmapped offsets
      rd_chk("R10 0x1C", 8'h1C, 32'h0);
      rd_chk("R10 0x40", 8'h40, 32'h0);
      rd_chk("R10 0x03", 8'h03, 32'h0);

      // R11: random mix against the model
      for (int it = 0; it < 4000; it++) begin
         @(negedge clk);
         chk("R11 pad_oe", pad_oe, m_dir);
         chk("R11 pad_out", pad_out, m_drive);
         chk("R11 irq", {30'h0, irq_hi, irq_lo},
             {30'h0, |(m_pend[31:16] & m_mask[31:16]), |(m_pend[15:0] & m_mask[15:0])});
         if ($urandom_range(0, 3) == 0) pad_in = pad_in ^ ($urandom() & $urandom());
         bus_addr = 8'($urandom_range(0, 8) * 4);
         bus_wdata = $urandom();
         bus_we = ($urandom_range(0, 2) == 0);
         if (!bus_we) begin
            #1 chk("R11 read", bus_rdata, exp_read(bus_addr));
         end
      end
      @(negedge clk); bus_we = 1'b0;

      finished = 1;
      summary();
   end
endmodule